// File: doc/BRIEF.md
# Key-Gated Routine Download Controller

This block is the control and status front end of an embedded flash controller. It keeps a sticky error flag that turns program/erase protection on, and it holds a one-shot request bit. When that bit is written, the block copies a chosen on-chip routine into RAM. Software reaches it through a small register bus. A key input and two execution-context qualifiers decide whether a request is honoured.

An accepted request starts the internal copy engine. The engine reads the routine selected by the select register from a computed routine ROM. It writes one word per cycle to RAM, beginning at the address held in the target register. When the last word goes out, the engine raises a one-cycle done pulse, and that pulse clears the request bit. Software therefore never reads the request bit as 1. It tracks progress through the busy output.

Top module: `fdl_top`

## Requirements
- R1: While reset is held and after it is released, all registers read 0 and `busy`, `prot_active`, `dl_done` and `ram_we` are 0.
- R2: A pulse on `err_evt` sets the error flag, which reads as bit 4 of register 0 and drives `prot_active`. Bus writes to register 0, including writes with any bit pattern, never clear it.
- R3: The error flag clears only when reset is asserted or when `stby` is high at a clock edge. If `stby` and `err_evt` are both high, `stby` wins.
- R4: Register 0 reads bits 3:1 and 15:5 as 0 whatever is written to them. Register 1 holds the routine select in bit 0, register 2 holds the RAM target address in bits 11:0, and register 3 reads 0.
- R5: A write with bit 0 = 1 to register 0 starts a download only when `key_val` is 0xA5, `run_in_ram` is 1 and `emu_active` is 0. Otherwise the write is dropped and no RAM write follows.
- R6: A download writes WORDS words, one per cycle, starting the cycle after the accepting edge. Word i goes to target+i and equals (i * 0x9E3779B1) XOR 0x00003C3C for routine 0, or XOR 0xC3C30000 for routine 1, keeping the low 32 bits.
- R7: Bit 0 of register 0 always reads 0, including during a download.
- R8: `busy` is high for WORDS+1 cycles, from the accepting edge until one cycle after the last copy. `dl_done` is high for exactly one cycle, during the last copy cycle.
- R9: A second accepted-looking request written while a copy is running is ignored. Exactly WORDS words are written and `busy` keeps its WORDS+1 length.
- R10: Writes to the select and target registers while a copy is running are ignored, and the registers read back their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stby | input | 1 | Hardware standby; clears the error flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| key_val | input | 8 | Current key register value |
| run_in_ram | input | 1 | CPU is executing from on-chip RAM |
| emu_active | input | 1 | RAM emulation mode is on |
| err_evt | input | 1 | Program/erase error condition pulse |
| prot_active | output | 1 | Error flag; protection active |
| busy | output | 1 | Download in progress |
| dl_done | output | 1 | One-cycle completion pulse |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 12 | RAM write address |
| ram_wdata | output | 32 | RAM write data |

## Verification
Downloads run with both routines and at two different target bases. A mix-up in the routine select or a fixed address offset would therefore show up as mismatched words or addresses. Requests are repeated with each qualifier failing in turn: a wrong key, execution outside RAM, and emulation switched on. This separates a complete three-way gate from one that checks only part of the condition. Requests and register writes issued in the middle of a copy show whether the running transfer is restarted or its parameters are disturbed. Error pulses mixed with writes and standby show which events the sticky flag responds to.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_SEL  = 2'd1,
    ADR_TGT  = 2'd2,
    ADR_NONE = 2'd3
  } fdl_reg_e;

  localparam logic [31:0] HASH_MUL = 32'h9E3779B1;

  function automatic logic [31:0] routine_word(input int unsigned routine, input int unsigned idx);
    logic [31:0] mix;
    mix = (routine == 0) ? 32'h00003C3C : 32'hC3C30000;
    return (32'(idx) * HASH_MUL) ^ mix;
  endfunction
endpackage

// File: rtl/fdl_regs.sv
module fdl_regs
  import fdl_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int RAM_AW   = 12,
  parameter int SEL_W    = 1,
  parameter logic [7:0] KEY_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [7:0]        key_val,
  input  logic              run_in_ram,
  input  logic              emu_active,
  input  logic              err_evt,
  input  logic              dl_done,
  output logic              req,
  output logic              err,
  output logic [SEL_W-1:0]  sel,
  output logic [RAM_AW-1:0] tgt
);
  localparam int ERR_BIT = 4;

  logic              req_q, req_d;
  logic              err_q, err_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [RAM_AW-1:0] tgt_q, tgt_d;
  logic              gate_ok, accept, cfg_open;

  assign gate_ok  = (key_val == KEY_CODE) && run_in_ram && !emu_active;
  assign accept   = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[0] && gate_ok && !req_q;
  assign cfg_open = bus_wr && !req_q;

  always_comb begin
    req_d = req_q;
    if (dl_done)     req_d = 1'b0;
    else if (accept) req_d = 1'b1;

    err_d = err_q;
    if (stby)         err_d = 1'b0;
    else if (err_evt) err_d = 1'b1;

    sel_d = sel_q;
    if (cfg_open && bus_addr == ADR_SEL) sel_d = bus_wdata[SEL_W-1:0];

    tgt_d = tgt_q;
    if (cfg_open && bus_addr == ADR_TGT) tgt_d = bus_wdata[RAM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      sel_q <= '0;
      tgt_q <= '0;
    end else begin
      req_q <= req_d;
      err_q <= err_d;
      sel_q <= sel_d;
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CTRL: bus_rdata[ERR_BIT]    = err_q;
      ADR_SEL:  bus_rdata[SEL_W-1:0]  = sel_q;
      ADR_TGT:  bus_rdata[RAM_AW-1:0] = tgt_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign req = req_q;
  assign err = err_q;
  assign sel = sel_q;
  assign tgt = tgt_q;
endmodule

// File: rtl/fdl_rom.sv
module fdl_rom
  import fdl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  parameter int SEL_W  = 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);
  localparam int NUM_R = 1 << SEL_W;

  logic [DATA_W-1:0] words [NUM_R];

  for (genvar r = 0; r < NUM_R; r++) begin : g_routine
    logic [31:0] full;
    always_comb full = routine_word(r, 32'(idx));
    assign words[r] = full[DATA_W-1:0];
  end

  assign word = words[sel];
endmodule

// File: rtl/fdl_mover.sv
module fdl_mover #(
  parameter int RAM_AW = 12,
  parameter int WORDS  = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [RAM_AW-1:0] tgt,
  output logic [CNT_W-1:0]  idx,
  output logic              done,
  output logic              busy,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tail_q;

  assign done   = req && (cnt_q == CNT_W'(WORDS - 1));
  assign cnt_en = req;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tail_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tail_q <= done;
    end
  end

  assign idx      = cnt_q;
  assign busy     = req | tail_q;
  assign ram_we   = req;
  assign ram_addr = tgt + RAM_AW'(cnt_q);
endmodule

// File: rtl/fdl_top.sv
module fdl_top #(
  parameter int BUS_W  = 16,
  parameter int RAM_AW = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  parameter logic [7:0] KEY_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [7:0]        key_val,
  input  logic              run_in_ram,
  input  logic              emu_active,
  input  logic              err_evt,
  output logic              prot_active,
  output logic              busy,
  output logic              dl_done,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SEL_W = 1;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              req;
  logic [SEL_W-1:0]  sel;
  logic [RAM_AW-1:0] tgt;
  logic [CNT_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fdl_regs #(.BUS_W(BUS_W), .RAM_AW(RAM_AW), .SEL_W(SEL_W), .KEY_CODE(KEY_CODE)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .stby(stby),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_val(key_val), .run_in_ram(run_in_ram), .emu_active(emu_active),
    .err_evt(err_evt), .dl_done(dl_done),
    .req(req), .err(prot_active), .sel(sel), .tgt(tgt)
  );

  fdl_mover #(.RAM_AW(RAM_AW), .WORDS(WORDS), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_int_n), .req(req), .tgt(tgt),
    .idx(idx), .done(dl_done), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr)
  );

  fdl_rom #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rom (
    .sel(sel), .idx(idx), .word(ram_wdata)
  );
endmodule

// File: rtl/fdl_chk.sv
module fdl_chk #(
  parameter int BUS_W = 16,
  parameter logic [7:0] KEY_CODE = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stby,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [7:0]       key_val,
  input logic             run_in_ram,
  input logic             emu_active,
  input logic             prot_active,
  input logic             busy,
  input logic             dl_done,
  input logic             ram_we
);
  logic start_ok;
  assign start_ok = bus_wr && bus_addr == 2'd0 && bus_wdata[0] &&
                    key_val == KEY_CODE && run_in_ram && !emu_active;

  AST_REQ_NEVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[0] == 1'b0 || bus_addr != 2'd0);                                // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> bus_rdata[3:1] == 3'b000);                           // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active && !stby |=> prot_active);                                    // R2
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> !prot_active);                                                   // R3
  AST_NO_START_UNQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start_ok |=> !ram_we);                                          // R5
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);                                                         // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dl_done |=> !dl_done);                                                    // R8
  AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    dl_done |=> busy && !ram_we);                                             // R8
endmodule

bind fdl_top fdl_chk #(.BUS_W(BUS_W), .KEY_CODE(KEY_CODE)) u_fdl_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_val(key_val),
  .run_in_ram(run_in_ram), .emu_active(emu_active), .prot_active(prot_active),
  .busy(busy), .dl_done(dl_done), .ram_we(ram_we)
);

// File: tb/tb_fdl_top.sv
module tb_fdl_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n, stby, bus_wr, run_in_ram, emu_active, err_evt;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  key_val;
  logic        prot_active, busy, dl_done, ram_we;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata;

  int checks = 0, errs = 0;
  bit finished = 1'b0;

  // Monitor state
  int          mon_words, mon_bad, busy_cyc, done_cyc;
  logic [11:0] exp_base;
  int          exp_sel;

  always #10 clk = ~clk;

  fdl_top dut (
    .clk(clk), .rst_n(rst_n), .stby(stby), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_val(key_val),
    .run_in_ram(run_in_ram), .emu_active(emu_active), .err_evt(err_evt),
    .prot_active(prot_active), .busy(busy), .dl_done(dl_done), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  function automatic logic [31:0] exp_word(int s, int i);
    return (32'(i) * 32'h9E3779B1) ^ ((s == 0) ? 32'h00003C3C : 32'hC3C30000);
  endfunction

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (dl_done) done_cyc++;
    if (ram_we) begin
      if (ram_addr !== exp_base + 12'(mon_words) || ram_wdata !== exp_word(exp_sel, mon_words))
        mon_bad++;
      mon_words++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clr_mon();
    mon_words = 0; mon_bad = 0; busy_cyc = 0; done_cyc = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk(d == 0, "R1", "ctrl in reset", d, 0);
    chk({busy, prot_active, dl_done, ram_we} == 0, "R1", "outputs in reset",
        {busy, prot_active, dl_done, ram_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, d); chk(d == 0, "R1", "sel after reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R1", "target after reset", d, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
  endtask

  task automatic t_err();
    logic [15:0] d;
    @(negedge clk); err_evt = 1'b1;
    @(negedge clk); err_evt = 1'b0;
    rd(2'd0, d); chk(d == 16'h0010, "R2", "err flag read", d, 16'h10);
    chk(prot_active == 1, "R2", "prot_active", prot_active, 1);
    wr(2'd0, 16'h0000); wr(2'd0, 16'hFFEE);
    rd(2'd0, d); chk(d == 16'h0010, "R2", "err flag after writes", d, 16'h10);
  endtask

  task automatic t_stby();
    logic [15:0] d;
    @(negedge clk); stby = 1'b1; err_evt = 1'b1;
    @(negedge clk); stby = 1'b0; err_evt = 1'b0;
    chk(prot_active == 0, "R3", "standby clears err", prot_active, 0);
    @(negedge clk); err_evt = 1'b1;
    @(negedge clk); err_evt = 1'b0;
    rst_n = 1'b0; #1;
    chk(prot_active == 0, "R3", "reset clears err", prot_active, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk(d == 0, "R3", "err stays clear", d, 0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    key_val = 8'h00;
    wr(2'd0, 16'hFFEE);
    rd(2'd0, d); chk(d == 0, "R4", "reserved ctrl bits", d, 0);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk(d == 0, "R4", "unused reg", d, 0);
    wr(2'd2, 16'hF123);
    rd(2'd2, d); chk(d == 16'h0123, "R4", "target width", d, 16'h0123);
    key_val = 8'hA5;
  endtask

  task automatic t_qual();
    clr_mon();
    key_val = 8'hA4; wr(2'd0, 16'h0001); repeat (3) @(negedge clk);
    chk(mon_words == 0 && busy_cyc == 0, "R5", "bad key", mon_words, 0);
    key_val = 8'hA5; run_in_ram = 1'b0; wr(2'd0, 16'h0001); repeat (3) @(negedge clk);
    chk(mon_words == 0 && busy_cyc == 0, "R5", "not in RAM", mon_words, 0);
    run_in_ram = 1'b1; emu_active = 1'b1; wr(2'd0, 16'h0001); repeat (3) @(negedge clk);
    chk(mon_words == 0 && busy_cyc == 0, "R5", "emulation on", mon_words, 0);
    emu_active = 1'b0;
  endtask

  task automatic t_download(int s, logic [11:0] base, bit second, bit poke);
    logic [15:0] d;
    wr(2'd1, 16'(s)); wr(2'd2, 16'(base));
    exp_sel = s; exp_base = base; clr_mon();
    wr(2'd0, 16'h0001);
    rd(2'd0, d); chk(d[0] == 0, "R7", "req bit during copy", d, 0);
    if (second) begin
      @(negedge clk); wr(2'd0, 16'h0001);
    end
    if (poke) begin
      wr(2'd1, 16'(1 - s)); wr(2'd2, 16'h0ABC);
    end
    repeat (N + 4) @(negedge clk);
    chk(mon_words == N, second ? "R9" : "R6", "word count", mon_words, N);
    chk(mon_bad == 0, "R6", "word addr/data mismatches", mon_bad, 0);
    chk(busy_cyc == N + 1, second ? "R9" : "R8", "busy length", busy_cyc, N + 1);
    chk(done_cyc == 1, "R8", "done pulses", done_cyc, 1);
    rd(2'd0, d); chk(d[0] == 0, "R7", "req bit after copy", d, 0);
    if (poke) begin
      rd(2'd1, d); chk(d == 16'(s), "R10", "select locked", d, s);
      rd(2'd2, d); chk(d == 16'(base), "R10", "target locked", d, base);
    end
  endtask

  initial begin
    rst_n = 1'b0; stby = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    key_val = 8'hA5; run_in_ram = 1'b1; emu_active = 1'b0; err_evt = 1'b0;
    clr_mon(); exp_base = '0; exp_sel = 0;
    t_reset();
    t_err();
    t_stby();
    t_reserved();
    t_qual();
    t_download(0, 12'h100, 1'b0, 1'b0);
    t_download(1, 12'h7F8, 1'b0, 1'b0);
    t_download(0, 12'h040, 1'b1, 1'b0);
    t_download(1, 12'h200, 1'b0, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule